// File: doc/BRIEF.md
# ALU Second-Operand Shifter with Carry-Out

This block produces the second operand of an ALU together with the shifter carry. It selects one of three operand sources: a 32-bit immediate, a register shifted by a 5-bit immediate amount, or a register shifted by an amount held in the low byte of a second register. The selected register value then passes through a barrel shifter that does logical left, logical right, arithmetic right, rotate right, or a one-bit rotate through the carry flag. The carry flag is the default carry-out.

When the source register index names the program counter, the block adds the pipeline read offset to the supplied register value. The offset is +8 in 32-bit instruction state and +4 in 16-bit instruction state. The operand and carry are registered, so they appear one clock after the inputs. The register file, flag writeback and the ALU itself are outside this block.

Top module: `shf_operand_unit`

## Requirements
- R1: While `rst_n` is low, `opnd_q` and `carry_q` are 0.
- R2: Source select encoding is 0 = immediate, 1 = register shifted by `shift_imm`, 2 = register shifted by `rs_val`, 3 = reserved. With select 0 the operand is `imm_val` and the carry is `c_flag`. With select 3 the operand is all ones and the carry is `c_flag`.
- R3: Shift kind 0 is logical left. For an amount n in 1..32 the result is the operand shifted left by n and the carry is operand bit 32-n. For n above 32 both the result and the carry are 0.
- R4: Shift kind 1 is logical right. For n in 1..32 the result is the operand shifted right by n and the carry is operand bit n-1. For n above 32 both the result and the carry are 0.
- R5: Shift kind 2 is arithmetic right, with vacated bits filled from bit 31. For n in 1..31 the carry is operand bit n-1. For n of 32 or more, every result bit and the carry equal operand bit 31.
- R6: Shift kind 3 is rotate right by n modulo 32. For nonzero n the carry equals bit 31 of the rotated result, so a rotate by 32 keeps the operand and copies its bit 31 to the carry.
- R7: Shift kind 4 rotates right by one through the carry. Bit 31 takes `c_flag`, and the carry takes the old bit 0. The amount is ignored.
- R8: For kinds 0..3, an amount of 0 passes the operand through unchanged with carry equal to `c_flag`. Kinds 5..7 always pass the operand through with carry equal to `c_flag`.
- R9: When `rm_idx` is 15, the operand is `rm_val` + 8 with `narrow_mode` low, or `rm_val` + 4 with `narrow_mode` high. Any other index uses `rm_val` unchanged.
- R10: In select 2 only `rs_val[7:0]` forms the amount, and bits 31..8 are ignored. In select 1 the amount is `shift_imm` zero-extended.
- R11: Results appear on the first rising clock edge after the inputs change, and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Operand source select |
| imm_val | input | 32 | Immediate operand |
| rm_idx | input | 4 | Index of the shifted source register |
| rm_val | input | 32 | Value read from the shifted source register |
| rs_val | input | 32 | Value read from the shift-amount register |
| shift_imm | input | 5 | Immediate shift amount |
| shift_kind | input | 3 | Shift type code |
| narrow_mode | input | 1 | 1 = 16-bit instruction state |
| c_flag | input | 1 | Current carry flag |
| opnd_q | output | 32 | Registered shifted operand |
| carry_q | output | 1 | Registered shifter carry-out |

## Verification
Every operand and carry is due one rising edge after its inputs are applied, since the only register on the path is the output stage. The bench changes inputs on a falling edge and samples on the following falling edge, which lies after exactly one rising edge. For the hold check it also samples just before the rising edge, where the previous result must still be present. Corner amounts 0, 1, 31, 32, 33 and 255 are checked explicitly, and a sweep of every kind over amounts 0..40 is compared against a bit-serial model.

// File: rtl/shf_pkg.sv
package shf_pkg;

    // Operand source select
    typedef enum logic [1:0] {
        SRC_IMM      = 2'd0,
        SRC_REG_IAMT = 2'd1,
        SRC_REG_RAMT = 2'd2,
        SRC_RSVD     = 2'd3
    } src_sel_e;

    // Shift kind codes (values 5..7 are pass-through)
    typedef enum logic [2:0] {
        SHK_LSL = 3'd0,
        SHK_LSR = 3'd1,
        SHK_ASR = 3'd2,
        SHK_ROR = 3'd3,
        SHK_RRX = 3'd4
    } shift_kind_e;

endpackage

// File: rtl/shf_srcsel.sv
module shf_srcsel #(
    parameter int WIDTH       = 32,
    parameter int AMT_W       = 8,
    parameter int IMM_AMT_W   = 5,
    parameter int IDX_W       = 4,
    parameter int PC_IDX      = 15,
    parameter int WIDE_STEP   = 4,
    parameter int NARROW_STEP = 2
) (
    input  logic [1:0]           src_sel,
    input  logic [IDX_W-1:0]     rm_idx,
    input  logic [WIDTH-1:0]     rm_val,
    input  logic [AMT_W-1:0]     rs_low,
    input  logic [IMM_AMT_W-1:0] shift_imm,
    input  logic                 narrow_mode,
    output logic [WIDTH-1:0]     base_val,
    output logic [AMT_W-1:0]     amount
);
    import shf_pkg::*;

    localparam logic [WIDTH-1:0] WIDE_OFS   = WIDTH'(2 * WIDE_STEP);
    localparam logic [WIDTH-1:0] NARROW_OFS = WIDTH'(2 * NARROW_STEP);
    localparam logic [IDX_W-1:0] PC_SEL     = IDX_W'(PC_IDX);

    logic is_pc;

    always_comb begin
        is_pc    = (rm_idx == PC_SEL);
        base_val = rm_val;
        if (is_pc) begin
            base_val = rm_val + (narrow_mode ? NARROW_OFS : WIDE_OFS);
        end
        if (src_sel == SRC_REG_RAMT) begin
            amount = rs_low;
        end else begin
            amount = {{(AMT_W-IMM_AMT_W){1'b0}}, shift_imm};
        end
    end

endmodule

// File: rtl/shf_core.sv
module shf_core #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  logic [WIDTH-1:0] operand,
    input  logic [2:0]       kind,
    input  logic [AMT_W-1:0] amount,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    import shf_pkg::*;

    localparam int ROT_W = $clog2(WIDTH);

    logic [WIDTH:0]          lsl_ext;
    logic [WIDTH:0]          lsr_ext;
    logic signed [WIDTH:0]   asr_ext;
    logic [2*WIDTH-1:0]      ror_dbl;
    logic [ROT_W-1:0]        rot_amt;

    always_comb begin
        // carry lands in the extra bit of each extended form
        lsl_ext = {1'b0, operand} << amount;
        lsr_ext = {operand, 1'b0} >> amount;
        asr_ext = $signed({operand, 1'b0}) >>> amount;
        rot_amt = amount[ROT_W-1:0];
        ror_dbl = {operand, operand} >> rot_amt;

        result    = operand;
        carry_out = carry_in;

        if (kind == SHK_RRX) begin
            result    = {carry_in, operand[WIDTH-1:1]};
            carry_out = operand[0];
        end else if (amount != '0) begin
            case (kind)
                SHK_LSL: begin
                    result    = lsl_ext[WIDTH-1:0];
                    carry_out = lsl_ext[WIDTH];
                end
                SHK_LSR: begin
                    result    = lsr_ext[WIDTH:1];
                    carry_out = lsr_ext[0];
                end
                SHK_ASR: begin
                    result    = asr_ext[WIDTH:1];
                    carry_out = asr_ext[0];
                end
                SHK_ROR: begin
                    result    = ror_dbl[WIDTH-1:0];
                    carry_out = ror_dbl[WIDTH-1];
                end
                default: begin
                    result    = operand;
                    carry_out = carry_in;
                end
            endcase
        end
    end

endmodule

// File: rtl/shf_operand_unit.sv
module shf_operand_unit #(
    parameter int WIDTH     = 32,
    parameter int AMT_W     = 8,
    parameter int IMM_AMT_W = 5,
    parameter int IDX_W     = 4,
    parameter int PC_IDX    = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           src_sel,
    input  logic [WIDTH-1:0]     imm_val,
    input  logic [IDX_W-1:0]     rm_idx,
    input  logic [WIDTH-1:0]     rm_val,
    input  logic [WIDTH-1:0]     rs_val,
    input  logic [IMM_AMT_W-1:0] shift_imm,
    input  logic [2:0]           shift_kind,
    input  logic                 narrow_mode,
    input  logic                 c_flag,
    output logic [WIDTH-1:0]     opnd_q,
    output logic                 carry_q
);
    import shf_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] value;
        logic             carry;
    } stage_t;

    stage_t           stage_d, stage_q;
    logic [WIDTH-1:0] base_val;
    logic [AMT_W-1:0] amount;
    logic [WIDTH-1:0] shifted;
    logic             shift_carry;

    shf_srcsel #(
        .WIDTH(WIDTH), .AMT_W(AMT_W), .IMM_AMT_W(IMM_AMT_W),
        .IDX_W(IDX_W), .PC_IDX(PC_IDX)
    ) i_srcsel (
        .src_sel     (src_sel),
        .rm_idx      (rm_idx),
        .rm_val      (rm_val),
        .rs_low      (rs_val[AMT_W-1:0]),
        .shift_imm   (shift_imm),
        .narrow_mode (narrow_mode),
        .base_val    (base_val),
        .amount      (amount)
    );

    shf_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) i_core (
        .operand   (base_val),
        .kind      (shift_kind),
        .amount    (amount),
        .carry_in  (c_flag),
        .result    (shifted),
        .carry_out (shift_carry)
    );

    always_comb begin
        stage_d.value = shifted;
        stage_d.carry = shift_carry;
        case (src_sel)
            SRC_IMM: begin
                stage_d.value = imm_val;
                stage_d.carry = c_flag;
            end
            SRC_RSVD: begin
                stage_d.value = '1;
                stage_d.carry = c_flag;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign opnd_q  = stage_q.value;
    assign carry_q = stage_q.carry;

    // ---------------- assertions ----------------
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!rst_n -> (opnd_q == '0 && !carry_q)));

    assert_imm_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_sel) == 2'd0)
        |-> (opnd_q == $past(imm_val) && carry_q == $past(c_flag)));

    assert_rsvd_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_sel) == 2'd3)
        |-> (opnd_q == '1 && carry_q == $past(c_flag)));

    assert_lsl_overrange_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_sel) == 2'd2 && $past(shift_kind) == 3'd0
         && $past(rs_val[AMT_W-1:0]) > AMT_W'(WIDTH))
        |-> (opnd_q == '0 && !carry_q));

    assert_ror_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_sel) == 2'd1 && $past(shift_kind) == 3'd3
         && $past(shift_imm) != '0)
        |-> (carry_q == opnd_q[WIDTH-1]));

    assert_rrx_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(src_sel) == 2'd1 || $past(src_sel) == 2'd2)
         && $past(shift_kind) == 3'd4)
        |-> (carry_q == $past(rm_val[0]) && opnd_q[WIDTH-1] == $past(c_flag)));

    assert_zero_amount_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_sel) == 2'd1 && $past(shift_imm) == '0
         && $past(shift_kind) != 3'd4)
        |-> (carry_q == $past(c_flag)));

    assert_amt_low_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_sel) == 2'd2 && $past(rs_val[AMT_W-1:0]) == '0
         && $past(rs_val[WIDTH-1:AMT_W]) != '0 && $past(shift_kind) != 3'd4)
        |-> (carry_q == $past(c_flag)));

endmodule

// File: tb/test_shf_operand_unit.sv
module test_shf_operand_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = '0;
    logic [31:0] imm_val = '0;
    logic [3:0]  rm_idx = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic [4:0]  shift_imm = '0;
    logic [2:0]  shift_kind = '0;
    logic        narrow_mode = 1'b0;
    logic        c_flag = 1'b0;
    logic [31:0] opnd_q;
    logic        carry_q;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    shf_operand_unit i_shf_operand_unit (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .imm_val(imm_val),
        .rm_idx(rm_idx), .rm_val(rm_val), .rs_val(rs_val), .shift_imm(shift_imm),
        .shift_kind(shift_kind), .narrow_mode(narrow_mode), .c_flag(c_flag),
        .opnd_q(opnd_q), .carry_q(carry_q)
    );

    // bit-serial reference: returns {carry, result}
    function automatic logic [32:0] ref_shift(input logic [2:0] k, input logic [31:0] op,
                                              input int amt, input logic cin);
        logic [31:0] r = op;
        logic        c = cin;
        if (k == 3'd4) begin
            c = op[0];
            r = {cin, op[31:1]};
        end else if (amt != 0 && k <= 3'd3) begin
            int steps = (k == 3'd3) ? (amt % 32) : amt;
            for (int i = 0; i < steps; i++) begin
                case (k)
                    3'd0: begin c = r[31]; r = r << 1; end
                    3'd1: begin c = r[0];  r = r >> 1; end
                    3'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
                    default: r = {r[0], r[31:1]};
                endcase
            end
            if (k == 3'd3) c = r[31];
        end
        return {c, r};
    endfunction

    task automatic check(input string req, input logic [31:0] exp_v, input logic exp_c);
        vectors++;
        if (opnd_q !== exp_v || carry_q !== exp_c) begin
            miscompares++;
            $display("FAIL %s: actual opnd=%08h carry=%0b expected opnd=%08h carry=%0b",
                     req, opnd_q, carry_q, exp_v, exp_c);
        end
    endtask

    // drive at falling edge, result due after next rising edge
    task automatic drive(input logic [1:0] s, input logic [2:0] k, input logic [31:0] rm,
                         input logic [3:0] idx, input logic [31:0] rs, input logic [4:0] si,
                         input logic cin, input logic nar);
        src_sel = s; shift_kind = k; rm_val = rm; rm_idx = idx; rs_val = rs;
        shift_imm = si; c_flag = cin; narrow_mode = nar;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_shift(input string req, input logic [2:0] k, input logic [31:0] op,
                             input logic [31:0] amt, input logic cin,
                             input logic [31:0] exp_v, input logic exp_c);
        drive(2'd2, k, op, 4'd3, amt, 5'd0, cin, 1'b0);
        check(req, exp_v, exp_c);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        src_sel = 2'd0; imm_val = 32'hDEAD_BEEF; c_flag = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 reset", 32'h0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_immediate;
        imm_val = 32'hA5A5_0F0F;
        drive(2'd0, 3'd0, 32'h1, 4'd2, 32'h4, 5'd3, 1'b1, 1'b0);
        check("R2 immediate", 32'hA5A5_0F0F, 1'b1);
        imm_val = 32'h0000_0001;
        drive(2'd0, 3'd1, 32'hFFFF_FFFF, 4'd15, 32'h4, 5'd3, 1'b0, 1'b0);
        check("R2 immediate", 32'h0000_0001, 1'b0);
        drive(2'd3, 3'd0, 32'h0, 4'd2, 32'h0, 5'd0, 1'b1, 1'b0);
        check("R2 reserved", 32'hFFFF_FFFF, 1'b1);
        drive(2'd3, 3'd0, 32'h0, 4'd2, 32'h0, 5'd0, 1'b0, 1'b0);
        check("R2 reserved", 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_latency;
        imm_val = 32'h1111_2222;
        drive(2'd0, 3'd0, 32'h0, 4'd0, 32'h0, 5'd0, 1'b0, 1'b0);
        imm_val = 32'h3333_4444; c_flag = 1'b1;
        #1;
        check("R11 hold before edge", 32'h1111_2222, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R11 one edge later", 32'h3333_4444, 1'b1);
    endtask

    task automatic t_lsl;
        reg_shift("R3 lsl 1",   3'd0, 32'h8000_0001, 1,   1'b0, 32'h0000_0002, 1'b1);
        reg_shift("R3 lsl 31",  3'd0, 32'h0000_0003, 31,  1'b0, 32'h8000_0000, 1'b1);
        reg_shift("R3 lsl 32",  3'd0, 32'h8000_0001, 32,  1'b0, 32'h0000_0000, 1'b1);
        reg_shift("R3 lsl 33",  3'd0, 32'hFFFF_FFFF, 33,  1'b1, 32'h0000_0000, 1'b0);
        reg_shift("R3 lsl 255", 3'd0, 32'hFFFF_FFFF, 255, 1'b1, 32'h0000_0000, 1'b0);
    endtask

    task automatic t_lsr;
        reg_shift("R4 lsr 1",  3'd1, 32'h8000_0001, 1,  1'b0, 32'h4000_0000, 1'b1);
        reg_shift("R4 lsr 32", 3'd1, 32'h8000_0000, 32, 1'b0, 32'h0000_0000, 1'b1);
        reg_shift("R4 lsr 33", 3'd1, 32'hFFFF_FFFF, 33, 1'b1, 32'h0000_0000, 1'b0);
    endtask

    task automatic t_asr;
        reg_shift("R5 asr 4 neg",  3'd2, 32'h8000_0008, 4,  1'b0, 32'hF800_0000, 1'b1);
        reg_shift("R5 asr 4 pos",  3'd2, 32'h7000_0000, 4,  1'b1, 32'h0700_0000, 1'b0);
        reg_shift("R5 asr 32 neg", 3'd2, 32'h8000_0000, 32, 1'b0, 32'hFFFF_FFFF, 1'b1);
        reg_shift("R5 asr 40 neg", 3'd2, 32'h8000_0000, 40, 1'b0, 32'hFFFF_FFFF, 1'b1);
        reg_shift("R5 asr 40 pos", 3'd2, 32'h7FFF_FFFF, 40, 1'b1, 32'h0000_0000, 1'b0);
    endtask

    task automatic t_ror;
        reg_shift("R6 ror 4",  3'd3, 32'h0000_00F1, 4,  1'b0, 32'h1000_000F, 1'b0);
        reg_shift("R6 ror 36", 3'd3, 32'h0000_00F1, 36, 1'b0, 32'h1000_000F, 1'b0);
        reg_shift("R6 ror 32", 3'd3, 32'h8000_0002, 32, 1'b0, 32'h8000_0002, 1'b1);
        reg_shift("R6 ror 32 pos", 3'd3, 32'h0000_0002, 32, 1'b1, 32'h0000_0002, 1'b0);
    endtask

    task automatic t_rrx;
        reg_shift("R7 rrx", 3'd4, 32'h0000_0003, 9, 1'b1, 32'h8000_0001, 1'b1);
        reg_shift("R7 rrx", 3'd4, 32'h8000_0002, 0, 1'b0, 32'h4000_0001, 1'b0);
    endtask

    task automatic t_zero;
        for (int k = 0; k < 4; k++) begin
            drive(2'd1, 3'(k), 32'h1234_5678, 4'd1, 32'h0, 5'd0, 1'b1, 1'b0);
            check("R8 zero amount", 32'h1234_5678, 1'b1);
        end
        for (int k = 5; k < 8; k++) begin
            reg_shift("R8 unused kind", 3'(k), 32'hCAFE_0001, 7, 1'b0, 32'hCAFE_0001, 1'b0);
        end
    endtask

    task automatic t_pc;
        drive(2'd1, 3'd0, 32'h0000_1000, 4'd15, 32'h0, 5'd0, 1'b0, 1'b0);
        check("R9 pc wide", 32'h0000_1008, 1'b0);
        drive(2'd1, 3'd0, 32'h0000_1000, 4'd15, 32'h0, 5'd0, 1'b0, 1'b1);
        check("R9 pc narrow", 32'h0000_1004, 1'b0);
        drive(2'd1, 3'd0, 32'h0000_1000, 4'd15, 32'h0, 5'd1, 1'b0, 1'b0);
        check("R9 pc wide shifted", 32'h0000_2010, 1'b0);
        drive(2'd1, 3'd0, 32'h0000_1000, 4'd14, 32'h0, 5'd0, 1'b0, 1'b0);
        check("R9 non-pc", 32'h0000_1000, 1'b0);
    endtask

    task automatic t_amount_src;
        reg_shift("R10 low byte", 3'd1, 32'h0000_00F0, 32'hFFFF_FF04, 1'b0, 32'h0000_000F, 1'b0);
        reg_shift("R10 upper ignored", 3'd0, 32'h8765_4321, 32'h0000_0100, 1'b1, 32'h8765_4321, 1'b1);
        drive(2'd1, 3'd0, 32'h0000_0003, 4'd2, 32'h0000_0004, 5'd31, 1'b0, 1'b0);
        check("R10 imm amount", 32'h8000_0000, 1'b1);
    endtask

    task automatic t_sweep;
        logic [32:0] e;
        logic [31:0] pats [3] = '{32'h8000_0001, 32'h5A3C_96E1, 32'h7FFF_FFFE};
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 5; k++) begin
                for (int a = 0; a <= 40; a++) begin
                    logic cin = 1'((a + k + p) & 1);
                    e = ref_shift(3'(k), pats[p], a, cin);
                    reg_shift($sformatf("R3-sweep kind %0d amt %0d (R4 R5 R6 R7)", k, a),
                              3'(k), pats[p], 32'(a), cin, e[31:0], e[32]);
                end
            end
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_immediate();
        t_latency();
        t_lsl();
        t_lsr();
        t_asr();
        t_ror();
        t_rrx();
        t_zero();
        t_pc();
        t_amount_src();
        t_sweep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            miscompares++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule